// File: doc/BRIEF.md
# Frame Conversion Command Queue

This block sits between a register write port and a frame-conversion engine. Software first enables the unit. It then programs the frame geometry, the input and output padding and the conversion mode. After that it streams conversion commands through one command address. Four successive writes to that address form one command: the luma base address, the first chroma base, the second chroma base and finally the destination base. Each complete command is held in a queue of two entries.

Whenever the engine is idle and a command is waiting, the block presents the oldest command together with a one-cycle start pulse. Each start corresponds to exactly one frame. When the engine signals done, the block sets a sticky end flag. An interrupt follows that flag if interrupts are enabled. A command word written while both entries are occupied is discarded and a sticky overflow flag is set. The software can read the fill level and a full flag from a status register.

Top module: `conv_cmd_queue`

## Requirements
- R1: While the enable bit (bit 0 of word address 0) is 0, writes to addresses 1 to 7 change nothing: configuration reads back 0 and command words start no frame.
- R2: Word addresses 1 to 5 hold width, height, input padding, output padding and mode. Each reads back its written value, zero-extended, and drives its configuration output.
- R3: A command is the four writes to address 6 in the order luma, chroma 1, chroma 2, destination. No start is issued before the fourth word has been taken.
- R4: When the engine is idle and a command is queued, eng_start is high for one cycle and eng_y/eng_u/eng_v/eng_out carry that command.
- R5: Status (address 7) bit 2 is the full flag and bits 4:3 give the number of queued, not yet started commands (0 to 2).
- R6: A command word written while two commands are queued is dropped and does not disturb later commands. It sets the sticky overflow bit, status bit 1, and writing 1 to that bit clears it.
- R7: Commands start in arrival order. A queued command starts in the cycle that follows the engine's done pulse.
- R8: A done pulse while a frame is running sets the sticky end bit, status bit 0. Writing 1 to that bit clears it. The bit is 0 after reset.
- R9: irq equals the end bit ANDed with the interrupt-enable bit (bit 1 of address 0).
- R10: Each accepted command causes exactly one start pulse. A done pulse while the engine is idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read word address |
| reg_rdata | output | 32 | Read data (combinational) |
| eng_start | output | 1 | One-cycle frame start to the engine |
| eng_y | output | 32 | Luma base of the started command |
| eng_u | output | 32 | First chroma base |
| eng_v | output | 32 | Second chroma base |
| eng_out | output | 32 | Destination base |
| eng_done | input | 1 | Engine frame-complete pulse |
| cfg_width | output | DIM_W | Frame width |
| cfg_height | output | DIM_W | Frame height |
| cfg_in_pad | output | DIM_W | Input padding |
| cfg_out_pad | output | DIM_W | Output padding |
| cfg_mode | output | MODE_W | Conversion mode |
| irq | output | 1 | Frame-end interrupt |

## Verification
The bench uses the default parameters: a depth of 2, 16-bit geometry fields and a 2-bit mode. At this size every ordering of six steps, each step either a command or a done pulse, can be run from reset, which gives 64 sequences. These sequences reach an empty queue, a full queue, drops on overflow, done pulses with nothing pending and back-to-back dispatch. Directed steps before the sweep cover the enable gate, configuration readback and the interrupt masking.

// File: rtl/convq_pkg.sv
// Shared definitions for the conversion command queue: word width,
// register word addresses, status bit positions and the command record.
package convq_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t y_base;
        word_t u_base;
        word_t v_base;
        word_t out_base;
    } conv_cmd_t;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_WIDTH  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HEIGHT = 3'd2;
    localparam logic [ADDR_W-1:0] A_INPAD  = 3'd3;
    localparam logic [ADDR_W-1:0] A_OUTPAD = 3'd4;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd5;
    localparam logic [ADDR_W-1:0] A_CMD    = 3'd6;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd7;

    localparam int ST_END  = 0;
    localparam int ST_OVF  = 1;
    localparam int ST_FULL = 2;
    localparam int ST_CNT  = 3;
endpackage

// File: rtl/conv_cmd_assembler.sv
// Collects command words into one command record.
// Assumes: word_we is already gated by the unit enable; accept is low
// while the queue is full, and a refused word leaves the word index as is.
module conv_cmd_assembler
    import convq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      word_we,
    input  word_t     word,
    input  logic      accept,
    output logic      cmd_push,
    output conv_cmd_t cmd
);
    localparam int WORDS = 4;
    localparam int LAST  = WORDS - 1;
    localparam int IDX_W = $clog2(WORDS);

    logic [IDX_W-1:0] idx;
    logic             take;

    assign take = word_we && accept;

    // Advance the word index on every accepted word, wrapping after the last.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (take)
            idx <= (idx == IDX_W'(LAST)) ? '0 : idx + IDX_W'(1);
    end

    for (genvar s = 0; s < LAST; s++) begin : g_stage
        word_t q;
        // Hold the word that arrived at position s of the command.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (take && idx == IDX_W'(s))
                q <= word;
        end
    end

    assign cmd_push = take && (idx == IDX_W'(LAST));
    assign cmd = '{y_base: g_stage[0].q, u_base: g_stage[1].q,
                   v_base: g_stage[2].q, out_base: word};

    // R6
    drop_keeps_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_we && !accept) |=> $stable(idx));
    // R3
    push_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push |=> (idx == '0));
endmodule

// File: rtl/conv_cmd_fifo.sv
// Small in-order store for complete commands.
// Assumes: the producer never pushes while full and the consumer never
// pops while empty.
module conv_cmd_fifo
    import convq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  conv_cmd_t                    din,
    input  logic                         pop,
    output conv_cmd_t                    dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    conv_cmd_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Store a pushed command at the write pointer.
    always_ff @(posedge clk) begin
        if (push)
            mem[wr_ptr] <= din;
    end

    // Track pointers and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/conv_dispatch.sv
// Hands the oldest queued command to the engine whenever it is idle and
// tracks the running frame.
// Assumes: eng_done is a single-cycle pulse; a done pulse while idle is ignored.
module conv_dispatch (
    input  logic clk,
    input  logic rst_n,
    input  logic has_cmd,
    input  logic eng_done,
    output logic start,
    output logic end_set
);
    logic busy;

    assign start   = !busy && has_cmd;
    assign end_set = busy && eng_done;

    // Busy from a start until the matching done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (start)
            busy <= 1'b1;
        else if (eng_done)
            busy <= 1'b0;
    end

    // R7
    next_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && has_cmd) |=> start);
    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
    // R4
    start_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/conv_reg_bank.sv
// Register bank: enable and interrupt-enable, static frame configuration,
// command-word forwarding, status with write-one-to-clear flags, readback.
// Assumes: only the control word is writable while the unit is disabled.
module conv_reg_bank
    import convq_pkg::*;
#(
    parameter int DIM_W  = 16,
    parameter int MODE_W = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  word_t             reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output word_t             reg_rdata,
    input  logic              end_set,
    input  logic              ovf_set,
    input  logic              q_full,
    input  logic [CNT_W-1:0]  q_count,
    output logic              cmd_we,
    output word_t             cmd_word,
    output logic [DIM_W-1:0]  cfg_width,
    output logic [DIM_W-1:0]  cfg_height,
    output logic [DIM_W-1:0]  cfg_in_pad,
    output logic [DIM_W-1:0]  cfg_out_pad,
    output logic [MODE_W-1:0] cfg_mode,
    output logic              irq
);
    logic  unit_en;
    logic  irq_en;
    logic  end_f;
    logic  ovf_f;
    logic  gated_we;
    logic  stat_we;
    word_t stat_word;

    assign gated_we = reg_we && unit_en;
    assign stat_we  = gated_we && (reg_addr == A_STAT);
    assign cmd_we   = gated_we && (reg_addr == A_CMD);
    assign cmd_word = reg_wdata;

    // Control word is writable regardless of the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_en <= 1'b0;
            irq_en  <= 1'b0;
        end else if (reg_we && reg_addr == A_CTRL) begin
            unit_en <= reg_wdata[0];
            irq_en  <= reg_wdata[1];
        end
    end

    // Static configuration, written only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_width   <= '0;
            cfg_height  <= '0;
            cfg_in_pad  <= '0;
            cfg_out_pad <= '0;
            cfg_mode    <= '0;
        end else if (gated_we) begin
            case (reg_addr)
                A_WIDTH:  cfg_width   <= reg_wdata[DIM_W-1:0];
                A_HEIGHT: cfg_height  <= reg_wdata[DIM_W-1:0];
                A_INPAD:  cfg_in_pad  <= reg_wdata[DIM_W-1:0];
                A_OUTPAD: cfg_out_pad <= reg_wdata[DIM_W-1:0];
                A_MODE:   cfg_mode    <= reg_wdata[MODE_W-1:0];
                default:  ;
            endcase
        end
    end

    // Sticky flags: a new event wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_f <= 1'b0;
            ovf_f <= 1'b0;
        end else begin
            end_f <= end_set || (end_f && !(stat_we && reg_wdata[ST_END]));
            ovf_f <= ovf_set || (ovf_f && !(stat_we && reg_wdata[ST_OVF]));
        end
    end

    // Assemble the status word.
    always_comb begin
        stat_word = '0;
        stat_word[ST_END]  = end_f;
        stat_word[ST_OVF]  = ovf_f;
        stat_word[ST_FULL] = q_full;
        stat_word[ST_CNT +: CNT_W] = q_count;
    end

    // Read multiplexer, zero-extending narrow fields.
    always_comb begin
        case (reg_raddr)
            A_CTRL:   reg_rdata = WORD_W'({irq_en, unit_en});
            A_WIDTH:  reg_rdata = WORD_W'(cfg_width);
            A_HEIGHT: reg_rdata = WORD_W'(cfg_height);
            A_INPAD:  reg_rdata = WORD_W'(cfg_in_pad);
            A_OUTPAD: reg_rdata = WORD_W'(cfg_out_pad);
            A_MODE:   reg_rdata = WORD_W'(cfg_mode);
            A_STAT:   reg_rdata = stat_word;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = end_f && irq_en;

    // R8
    end_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_set |=> end_f);
    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> ovf_f);
    // R1
    gate_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_en && reg_we && reg_addr == A_WIDTH) |=> $stable(cfg_width));
endmodule

// File: rtl/conv_cmd_queue.sv
// Top level: register port in, queued conversion commands out to the
// frame engine, end interrupt back to software.
// Assumes: the engine accepts a start only when this block issues it and
// answers each start with one done pulse.
module conv_cmd_queue
    import convq_pkg::*;
#(
    parameter int DEPTH  = 2,
    parameter int DIM_W  = 16,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [2:0]        reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              eng_start,
    output logic [31:0]       eng_y,
    output logic [31:0]       eng_u,
    output logic [31:0]       eng_v,
    output logic [31:0]       eng_out,
    input  logic              eng_done,
    output logic [DIM_W-1:0]  cfg_width,
    output logic [DIM_W-1:0]  cfg_height,
    output logic [DIM_W-1:0]  cfg_in_pad,
    output logic [DIM_W-1:0]  cfg_out_pad,
    output logic [MODE_W-1:0] cfg_mode,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             cmd_we;
    word_t            cmd_word;
    logic             cmd_push;
    conv_cmd_t        new_cmd;
    conv_cmd_t        head_cmd;
    logic [CNT_W-1:0] q_count;
    logic             q_full;
    logic             q_empty;
    logic             end_set;
    logic             ovf_set;

    assign ovf_set = cmd_we && q_full;

    conv_reg_bank #(.DIM_W(DIM_W), .MODE_W(MODE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .end_set(end_set), .ovf_set(ovf_set),
        .q_full(q_full), .q_count(q_count),
        .cmd_we(cmd_we), .cmd_word(cmd_word),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_in_pad(cfg_in_pad), .cfg_out_pad(cfg_out_pad),
        .cfg_mode(cfg_mode), .irq(irq)
    );

    conv_cmd_assembler u_asm (
        .clk(clk), .rst_n(rst_n),
        .word_we(cmd_we), .word(cmd_word), .accept(!q_full),
        .cmd_push(cmd_push), .cmd(new_cmd)
    );

    conv_cmd_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_push), .din(new_cmd),
        .pop(eng_start), .dout(head_cmd),
        .count(q_count), .full(q_full), .empty(q_empty)
    );

    conv_dispatch u_disp (
        .clk(clk), .rst_n(rst_n),
        .has_cmd(!q_empty), .eng_done(eng_done),
        .start(eng_start), .end_set(end_set)
    );

    assign eng_y   = head_cmd.y_base;
    assign eng_u   = head_cmd.u_base;
    assign eng_v   = head_cmd.v_base;
    assign eng_out = head_cmd.out_base;

    // R6
    full_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !eng_start) |=> (q_count == $past(q_count)));
endmodule

// File: tb/sim_conv_cmd_queue.sv
module sim_conv_cmd_queue;
    import convq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        eng_start;
    logic [31:0] eng_y, eng_u, eng_v, eng_out;
    logic        eng_done = 1'b0;
    logic [15:0] cfg_width, cfg_height, cfg_in_pad, cfg_out_pad;
    logic [1:0]  cfg_mode;
    logic        irq;

    conv_cmd_queue u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .eng_start(eng_start), .eng_y(eng_y), .eng_u(eng_u), .eng_v(eng_v),
        .eng_out(eng_out), .eng_done(eng_done),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_in_pad(cfg_in_pad), .cfg_out_pad(cfg_out_pad),
        .cfg_mode(cfg_mode), .irq(irq)
    );

    always #4 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // bench model
    int pend, nexp, na;
    bit busy, endf, ovff, iem;
    int q [2];
    logic [31:0] exp_log [32];
    logic [31:0] act_log [32];

    function automatic logic [31:0] val(input int id, input int w);
        return 32'hA000_0000 | (32'(id) << 8) | 32'(w);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        pend = 0; nexp = 0; busy = 0; endf = 0; ovff = 0; iem = 0;
    endtask

    task automatic dispatch_chk();
        if (!busy && pend > 0) begin
            chk("R7 start expected", 32'(eng_start), 1);
            chk("R4 luma", eng_y, val(q[0], 0));
            chk("R4 chroma1", eng_u, val(q[0], 1));
            chk("R4 chroma2", eng_v, val(q[0], 2));
            chk("R4 dest", eng_out, val(q[0], 3));
            exp_log[nexp] = val(q[0], 0);
            nexp++;
            q[0] = q[1];
            pend--;
            busy = 1;
        end else begin
            chk("R10 no start", 32'(eng_start), 0);
        end
    endtask

    task automatic push_cmd(input int id);
        for (int w = 0; w < 4; w++) begin
            wr(A_CMD, val(id, w));
            if (w < 3) chk("R3 early start", 32'(eng_start), 0);
        end
        if (pend == 2) ovff = 1;
        else begin
            q[pend] = id;
            pend++;
        end
        dispatch_chk();
    endtask

    task automatic done_op();
        @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        if (busy) begin
            busy = 0;
            endf = 1;
        end
        dispatch_chk();
    endtask

    task automatic stat_chk();
        logic [31:0] s;
        @(negedge clk);
        rd(A_STAT, s);
        chk("R8 end bit", 32'(s[0]), 32'(endf));
        chk("R6 overflow bit", 32'(s[1]), 32'(ovff));
        chk("R5 full bit", 32'(s[2]), 32'(pend == 2));
        chk("R5 count", 32'(s[4:3]), 32'(pend));
        chk("R9 irq", 32'(irq), 32'(endf && iem));
    endtask

    // log every start seen at the ports
    always @(negedge clk) begin
        if (rst_n !== 1'b1) na = 0;
        else if (eng_start === 1'b1 && na < 32) begin
            act_log[na] = eng_y;
            na++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int id;
        do_reset();
        // reset state
        rd(A_STAT, r);
        chk("R8 reset status", r, 0);
        chk("R4 reset start", 32'(eng_start), 0);
        chk("R9 reset irq", 32'(irq), 0);

        // R1: disabled unit ignores writes
        wr(A_WIDTH, 32'h55);
        rd(A_WIDTH, r);
        chk("R1 width readback", r, 0);
        chk("R1 width pin", 32'(cfg_width), 0);
        for (int w = 0; w < 4; w++) wr(A_CMD, val(9, w));
        chk("R1 no start", 32'(eng_start), 0);
        stat_chk();

        // R2: configuration
        wr(A_CTRL, 32'h1);
        wr(A_WIDTH, 32'hFFFF_1234);
        wr(A_HEIGHT, 32'h0000_0ABC);
        wr(A_INPAD, 32'h0000_0030);
        wr(A_OUTPAD, 32'h0000_0010);
        wr(A_MODE, 32'h0000_0006);
        rd(A_WIDTH, r);  chk("R2 width", r, 32'h1234);
        rd(A_HEIGHT, r); chk("R2 height", r, 32'h0ABC);
        rd(A_INPAD, r);  chk("R2 in pad", r, 32'h30);
        rd(A_OUTPAD, r); chk("R2 out pad", r, 32'h10);
        rd(A_MODE, r);   chk("R2 mode", r, 32'h2);
        chk("R2 width pin", 32'(cfg_width), 32'h1234);
        chk("R2 height pin", 32'(cfg_height), 32'h0ABC);
        chk("R2 in pad pin", 32'(cfg_in_pad), 32'h30);
        chk("R2 out pad pin", 32'(cfg_out_pad), 32'h10);
        chk("R2 mode pin", 32'(cfg_mode), 32'h2);

        // R9: masked interrupt, then unmasked; R8 clear
        push_cmd(1);
        done_op();
        stat_chk();
        chk("R9 masked irq", 32'(irq), 0);
        wr(A_CTRL, 32'h3); iem = 1;
        chk("R9 enabled irq", 32'(irq), 1);
        wr(A_STAT, 32'h1); endf = 0;
        stat_chk();

        // R5/R6: fill, overflow, clear
        push_cmd(2); push_cmd(3); push_cmd(4);
        stat_chk();
        push_cmd(5);
        stat_chk();
        wr(A_STAT, 32'h2); ovff = 0;
        stat_chk();
        done_op(); done_op(); done_op(); done_op();
        stat_chk();
        chk("R7 count directed", 32'(na), 32'(nexp));
        for (int i = 0; i < nexp; i++) chk("R7 order directed", act_log[i], exp_log[i]);

        // sweep: all 6-step orderings of command / done
        for (int s = 0; s < 64; s++) begin
            do_reset();
            wr(A_CTRL, 32'h3); iem = 1;
            id = 16;
            for (int b = 0; b < 6; b++) begin
                if (s[b]) begin
                    push_cmd(id);
                    id++;
                end else done_op();
            end
            stat_chk();
            chk("R10 start count", 32'(na), 32'(nexp));
            for (int i = 0; i < nexp; i++) chk("R7 order", act_log[i], exp_log[i]);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule